// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Controller

This block closes the feedback path of a frequency synthesizer built around an external 15/16 dual-modulus prescaler. It runs on the prescaler output, so every clock edge it sees is one prescaler period. It drives the prescaler's modulus select line, and once per division cycle it emits a one-period pulse toward the phase comparator. The VCO frequency divided by the pulse rate is the overall feedback ratio.

A 13-bit channel word sets the ratio. Its upper nine bits (`[12:4]`) are the start value P of an up-counter that runs to a full count of 512, so a cycle lasts 512 − P prescaler periods. Its lower four bits (`[3:0]`) are the swallow value A. The modulus select stays high (divide by 15) for the first 12 + A periods of a cycle. It then drops low (divide by 16) for the remaining periods. The overall ratio in VCO cycles is 16·(512 − P) − (12 + A).

A channel word is captured on a load strobe into a holding register. It is applied only when the current cycle finishes, so a running cycle is never disturbed. Synchronous reset clears both the holding register and the active word to zero, which gives a ratio of 8180.

Top module: `swallow_divider`

## Requirements
- R1: While reset is high, at every prescaler edge `mod_sel` is driven to 1 and `div_out` to 0. A `mod_sel` value of 1 selects divide-by-15 and 0 selects divide-by-16.
- R2: In the prescaler period in which `div_out` is high, `mod_sel` is high, so every cycle begins at divide-by-15.
- R3: In each cycle, `mod_sel` is high for exactly min(12 + A, 512 − P) prescaler periods, all at the start of the cycle, and then stays low until the cycle ends.
- R4: A division cycle lasts exactly 512 − P prescaler periods, counted from one `div_out` period to the next, where P = `chan_word[12:4]`.
- R5: When 12 + A < 512 − P, with A = `chan_word[3:0]`, the time between `div_out` rising edges is 16·(512 − P) − (12 + A) VCO cycles.
- R6: `div_out` is high for exactly one prescaler period per cycle (for P ≤ 510), namely the first period after the full count is reached.
- R7: When 12 + A ≥ 512 − P, the main count finishes first, `mod_sel` never drops in that cycle, and the ratio is 15·(512 − P).
- R8: A word loaded while a cycle is running does not change that cycle. It takes effect from the next full-count restart.
- R9: After reset, with no load, every cycle uses P = 0 and A = 0, which gives 512 periods and a ratio of 8180 VCO cycles.
- R10: `mod_sel` goes from low to high only in a period where `div_out` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output; one rising edge per prescaler period |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Captures `chan_word` into the holding register on this edge |
| chan_word | input | 13 | `[12:4]` main start value P, `[3:0]` swallow value A |
| mod_sel | output | 1 | Prescaler modulus select: 1 = divide by 15, 0 = divide by 16 |
| div_out | output | 1 | Divided pulse, one prescaler period wide per cycle |

## Verification
The bench models the prescaler and counts VCO edges between divided pulses. It also counts prescaler periods, and periods with `mod_sel` high, within each cycle. The reset word (P = 0, A = 0) checks the longest cycle against the known 8180 ratio. Directed words on both sides of the boundary 12 + A = 512 − P separate the normal two-phase cycle from the case where the full count ends the cycle before the swallow count does. Random words with seeded P and A test the general formula. Each load is made just after a cycle starts, so the ratio of the cycle in progress must still match the old word; this exposes any word applied too early.

// File: rtl/swallow_divider_pkg.sv
package swallow_divider_pkg;
  localparam int DEF_MAIN_W    = 9;
  localparam int DEF_SWAL_W    = 4;
  localparam int DEF_SWAL_BASE = 12;
endpackage

// File: rtl/swallow_hold_reg.sv
module swallow_hold_reg #(
  parameter int MAIN_W = swallow_divider_pkg::DEF_MAIN_W,
  parameter int SWAL_W = swallow_divider_pkg::DEF_SWAL_W,
  localparam int WORD_W = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word_in,
  input  logic              restart,
  output logic [MAIN_W-1:0] next_start,
  output logic [SWAL_W-1:0] active_swal
);
  logic [WORD_W-1:0] hold_q;

  // Holding register: written by the load strobe at any time.
  always_ff @(posedge clk) begin
    if (rst)          hold_q <= '0;
    else if (load_en) hold_q <= word_in;
  end

  // The swallow value in use changes only at a cycle restart.
  always_ff @(posedge clk) begin
    if (rst)          active_swal <= '0;
    else if (restart) active_swal <= hold_q[SWAL_W-1:0];
  end

  assign next_start = hold_q[WORD_W-1:SWAL_W];
endmodule

// File: rtl/swallow_main_count.sv
module swallow_main_count #(
  parameter int MAIN_W = swallow_divider_pkg::DEF_MAIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAIN_W-1:0] start_val,
  output logic              full_hit
);
  logic [MAIN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (full_hit) cnt_q <= start_val;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // The top value is the last period before the full count wraps.
  assign full_hit = (cnt_q == {MAIN_W{1'b1}});
endmodule

// File: rtl/swallow_mod_ctrl.sv
module swallow_mod_ctrl #(
  parameter int SWAL_W    = swallow_divider_pkg::DEF_SWAL_W,
  parameter int SWAL_BASE = swallow_divider_pkg::DEF_SWAL_BASE,
  localparam int SC_W     = $clog2(SWAL_BASE + (1 << SWAL_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [SWAL_W-1:0] swal_val,
  output logic              mod_hi
);
  logic [SC_W-1:0] sc_q;
  logic [SC_W-1:0] sc_next;
  logic [SC_W-1:0] sc_end;

  assign sc_next = sc_q + SC_W'(1);
  assign sc_end  = SC_W'(SWAL_BASE) + SC_W'(swal_val);

  // A restart has priority over the swallow end.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sc_q   <= '0;
      mod_hi <= 1'b1;
    end else if (mod_hi) begin
      sc_q <= sc_next;
      if (sc_next == sc_end) mod_hi <= 1'b0;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int MAIN_W    = swallow_divider_pkg::DEF_MAIN_W,
  parameter int SWAL_W    = swallow_divider_pkg::DEF_SWAL_W,
  parameter int SWAL_BASE = swallow_divider_pkg::DEF_SWAL_BASE,
  localparam int WORD_W   = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [WORD_W-1:0] chan_word,
  output logic              mod_sel,
  output logic              div_out
);
  logic              full_hit;
  logic [MAIN_W-1:0] next_start;
  logic [SWAL_W-1:0] active_swal;

  swallow_hold_reg #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .load_en     (load_en),
    .word_in     (chan_word),
    .restart     (full_hit),
    .next_start  (next_start),
    .active_swal (active_swal)
  );

  swallow_main_count #(.MAIN_W(MAIN_W)) u_main (
    .clk       (clk),
    .rst       (rst),
    .start_val (next_start),
    .full_hit  (full_hit)
  );

  swallow_mod_ctrl #(.SWAL_W(SWAL_W), .SWAL_BASE(SWAL_BASE)) u_mod (
    .clk      (clk),
    .rst      (rst),
    .restart  (full_hit),
    .swal_val (active_swal),
    .mod_hi   (mod_sel)
  );

  // The divided pulse is registered on the full-count event.
  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= full_hit;
  end
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int SWAL_W    = swallow_divider_pkg::DEF_SWAL_W,
  parameter int SWAL_BASE = swallow_divider_pkg::DEF_SWAL_BASE
) (
  input logic clk,
  input logic rst,
  input logic mod_sel,
  input logic div_out
);
  localparam int HI_MAX = SWAL_BASE + (1 << SWAL_W) - 1;
  logic [7:0] hi_cnt;

  // Counts the periods with mod_sel high since the last divided pulse.
  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= '0;
    else if (div_out) hi_cnt <= 8'd1;
    else if (mod_sel && hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 8'd1;
  end

  assert_start_high_R2: assert property (@(posedge clk) disable iff (rst)
    div_out |-> mod_sel);

  assert_rise_at_restart_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_sel) |-> div_out);

  assert_low_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !mod_sel |=> (mod_sel == div_out));

  assert_high_bound_R3: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= 8'(HI_MAX));
endmodule

bind swallow_divider swallow_divider_chk #(.SWAL_W(SWAL_W), .SWAL_BASE(SWAL_BASE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mod_sel (mod_sel),
  .div_out (div_out)
);

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  localparam int WD_LIMIT = 190000;

  logic        vco = 1'b0;
  logic        pclk = 1'b0;
  logic        rst = 1'b1;
  logic        ld = 1'b0;
  logic [12:0] word = '0;
  logic        mod_sel, div_out;

  int n_chk = 0, n_bad = 0;
  int vcount = 0, lastv = 0, intv = 0, npulse = 0;
  bit prevp = 1'b0, prev_s = 1'b0;
  int per = 0, hi = 0, last_per = 0, last_hi = 0;
  int width_err = 0, start_err = 0;
  int ps_cnt = 0, ps_len = 16;
  int cur_p = 0, cur_a = 0;
  bit done = 1'b0;

  always #2.5 vco = ~vco;

  swallow_divider u_swallow_divider (
    .clk(pclk), .rst(rst), .load_en(ld), .chan_word(word),
    .mod_sel(mod_sel), .div_out(div_out)
  );

  // Behavioural 15/16 prescaler; modulus sampled early in each period.
  always @(posedge vco) begin
    if (ps_cnt >= ps_len - 1) begin
      ps_cnt <= 0;
      pclk   <= 1'b1;
    end else begin
      ps_cnt <= ps_cnt + 1;
      pclk   <= 1'b0;
      if (ps_cnt == 1) ps_len <= (mod_sel === 1'b0) ? 16 : 15;
    end
  end

  always @(posedge vco) vcount++;

  always @(negedge vco) begin
    if (div_out === 1'b1 && !prevp && !rst) begin
      intv  = vcount - lastv;
      lastv = vcount;
      npulse++;
    end
    prevp = (div_out === 1'b1);
  end

  always @(negedge pclk) begin
    if (!rst) begin
      if (div_out === 1'b1) begin
        last_per = per;
        last_hi  = hi;
        if (prev_s) width_err++;
        if (mod_sel !== 1'b1) start_err++;
        per = 1;
        hi  = (mod_sel === 1'b1) ? 1 : 0;
      end else begin
        per++;
        if (mod_sel === 1'b1) hi++;
      end
      prev_s = (div_out === 1'b1);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge vco) begin
    if (vcount > WD_LIMIT && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", vcount, WD_LIMIT);
      summary();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input int p, input int a);
    int n = 512 - p;
    int s = 12 + a;
    return (s >= n) ? 15 * n : 16 * n - s;
  endfunction

  function automatic int hi_periods(input int p, input int a);
    int n = 512 - p;
    int s = 12 + a;
    return (s >= n) ? n : s;
  endfunction

  task automatic wait_pulse();
    int t = npulse;
    wait (npulse != t);
    @(negedge pclk);
    #1;
  endtask

  // Entered in the first period of a cycle; the load lands mid-cycle.
  task automatic run_word(input int p, input int a);
    ld   = 1'b1;
    word = {9'(p), 4'(a)};
    @(negedge pclk);
    #1 ld = 1'b0;
    wait_pulse();
    check("R8 cycle in progress keeps old word", intv, ratio(cur_p, cur_a));
    wait_pulse();
    if (12 + a >= 512 - p) check("R7 ratio, main count ends first", intv, ratio(p, a));
    else                   check("R5 ratio", intv, ratio(p, a));
    check("R4 periods per cycle", last_per, 512 - p);
    check("R3 divide-by-15 periods", last_hi, hi_periods(p, a));
    cur_p = p;
    cur_a = a;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20250611);
    repeat (6) @(posedge pclk);
    @(negedge pclk);
    check("R1 mod_sel in reset", int'(mod_sel === 1'b1), 1);
    check("R1 div_out in reset", int'(div_out === 1'b0), 1);
    rst = 1'b0;
    wait_pulse();
    wait_pulse();
    check("R9 reset word ratio", intv, 8180);
    check("R9 reset word periods (R4)", last_per, 512);
    check("R9 reset word divide-by-15 periods (R3)", last_hi, 12);
    run_word(256, 0);
    run_word(400, 7);
    run_word(487, 12);
    run_word(488, 12);
    run_word(500, 0);
    run_word(505, 15);
    run_word(510, 3);
    run_word(300, 15);
    for (int i = 0; i < 10; i++) begin
      run_word(300 + int'($urandom % 211), int'($urandom % 16));
    end
    check("R6 pulse width violations", width_err, 0);
    check("R2 cycles starting at divide-by-16", start_err, 0);
    done = 1'b1;
    summary();
  end
endmodule